// File: doc/BRIEF.md
# Byte-Programmed Interrupt Controller Front End

This block is the register side of a classic eight-line interrupt controller. A CPU reaches it through one register-select bit (`addr`), a byte write bus and a byte read bus. Writes to the even address carry command bytes. Writes to the odd address are steered by a small setup sequencer. Right after a setup restart, the same odd-address byte is taken in turn as the vector base, then the optional cascade word, then the optional mode word. Once setup is complete, each odd-address byte becomes the interrupt mask.

The block samples eight request lines every clock. It ranks the unmasked ones with line 0 highest and raises `int_out` when the winning request outranks everything already in service. It presents the winning line number and the vector built from the programmed base. A one-cycle `int_take` pulse moves the winning line into service. A non-specific end-of-interrupt command clears the most urgent in-service line. Cascading, rotating priority and the bus acknowledge handshake are not part of this block.

Top module: `irqc_top`

## Requirements
- R1: An even-address write with bit 4 set is a setup restart. It zeroes the mask and in-service registers, turns special mask mode off, selects the request register for even reads, and makes the next odd-address write the vector base.
- R2: The first odd-address write after a setup restart loads the vector base. `int_vector` equals base bits 7..3 followed by the 3-bit `int_level`.
- R3: After the base, a cascade word is consumed only if bit 1 of the restart byte was 0, and a mode word only if bit 0 of the restart byte was 1. After the last expected word the sequencer is idle.
- R4: With the sequencer idle, an odd-address write loads the mask register. An odd-address read returns the mask.
- R5: An even-address write with bit 4 = 0 and bit 3 = 1 is a read/mode command. If its bit 1 is 1, its bit 0 selects the source of even reads (1 = in-service register, 0 = request register). If bit 1 is 0, the selection is unchanged.
- R6: In that read/mode command, bit 6 = 1 sets special mask mode to the value of bit 5. Bit 6 = 0 leaves the mode unchanged.
- R7: An even-address write with (byte AND 0xB8) = 0x20 clears the lowest-numbered set bit of the in-service register. If the register is empty, it has no effect. Other even-address bytes that match none of these commands, such as 0xA0, change nothing.
- R8: The request register copies `irq_lines` on every clock. `int_level` is the lowest-numbered request that is both set and unmasked.
- R9: `int_out` is 1 when an unmasked request exists and its line number is lower than every in-service bit. In special mask mode, in-service bits whose mask bit is set are left out of this comparison.
- R10: `int_take` while `int_out` is 1 sets the in-service bit of `int_level`. `int_take` while `int_out` is 0 is ignored.
- R11: After reset, the mask, in-service, request and base registers are zero, the sequencer is idle, even reads return the request register, and `int_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| addr | input | 1 | Register select: 0 = command, 1 = data/mask |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte: the request or in-service register for addr 0, the mask for addr 1 |
| irq_lines | input | 8 | Interrupt request lines, sampled each clock |
| int_take | input | 1 | Moves the current winner into service |
| int_out | output | 1 | Interrupt pending towards the CPU |
| int_level | output | 3 | Line number of the winning request |
| int_vector | output | 8 | Vector for the winning request |

## Verification
The assertions check on every cycle that a setup restart empties the mask and in-service registers, and that an idle odd write lands in the mask. They also check that the sequencer never moves without a write, that an end-of-interrupt removes exactly one in-service bit, that a raised `int_out` always has an unmasked request behind it, and that a taken interrupt appears in service. The order in which setup words are consumed for each restart byte can only be shown by the bench scenarios. The same holds for read-select persistence, special-mask unblocking, the ignored command byte and the ignored take. The bench shows these by comparing against its reference model on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Setup sequencer position: which word the next odd-address write is
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_t;

  // Bit positions within command bytes
  localparam int RESTART_BIT = 4;
  localparam int RDCMD_BIT   = 3;
  localparam int SINGLE_BIT  = 1;
  localparam int MODEW_BIT   = 0;
  localparam int RSEL_EN_BIT = 1;
  localparam int RSEL_BIT    = 0;
  localparam int SMM_EN_BIT  = 6;
  localparam int SMM_BIT     = 5;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [LW-1:0] idx,
  output logic [N-1:0]  onehot
);
  // Lowest index wins
  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx    = LW'(i);
        onehot = N'(1) << i;
      end
    end
  end

  assign any = |vec;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] imr_q,
  output logic [DW-1:LW] base_q,
  output logic          rd_isr_q,
  output logic          smm_q,
  output seq_t          stage_q,
  output logic          restart_hit,
  output logic          eoi_hit
);
  logic    even_wr, odd_wr, rdcmd_hit;
  logic    need_casc_q, need_mode_q, need_casc_d, need_mode_d;
  logic    imr_en, base_en, flags_en;
  logic    rd_isr_d, smm_d;
  logic [DW-1:0] imr_d;
  seq_t    stage_d;

  assign even_wr     = wr_en & ~addr;
  assign odd_wr      = wr_en &  addr;
  assign restart_hit = even_wr & wdata[RESTART_BIT];
  assign rdcmd_hit   = even_wr & ~wdata[RESTART_BIT] & wdata[RDCMD_BIT];
  assign eoi_hit     = even_wr & ~wdata[7] & wdata[5] & ~wdata[4] & ~wdata[3];

  // Next-state logic
  always_comb begin
    stage_d     = stage_q;
    need_casc_d = need_casc_q;
    need_mode_d = need_mode_q;
    imr_d       = imr_q;
    rd_isr_d    = rd_isr_q;
    smm_d       = smm_q;
    imr_en      = 1'b0;
    base_en     = 1'b0;
    flags_en    = 1'b0;
    if (restart_hit) begin
      stage_d     = SEQ_BASE;
      need_casc_d = ~wdata[SINGLE_BIT];
      need_mode_d = wdata[MODEW_BIT];
      imr_d       = '0;
      imr_en      = 1'b1;
      rd_isr_d    = 1'b0;
      smm_d       = 1'b0;
      flags_en    = 1'b1;
    end else begin
      if (rdcmd_hit) begin
        if (wdata[RSEL_EN_BIT]) rd_isr_d = wdata[RSEL_BIT];
        if (wdata[SMM_EN_BIT])  smm_d    = wdata[SMM_BIT];
      end
      if (odd_wr) begin
        unique case (stage_q)
          SEQ_IDLE: begin
            imr_d  = wdata;
            imr_en = 1'b1;
          end
          SEQ_BASE: begin
            base_en = 1'b1;
            stage_d = need_casc_q ? SEQ_CASC : (need_mode_q ? SEQ_MODE : SEQ_IDLE);
          end
          SEQ_CASC: stage_d = need_mode_q ? SEQ_MODE : SEQ_IDLE;
          SEQ_MODE: stage_d = SEQ_IDLE;
          default:  stage_d = SEQ_IDLE;
        endcase
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q     <= SEQ_IDLE;
      need_casc_q <= 1'b0;
      need_mode_q <= 1'b0;
      imr_q       <= '0;
      base_q      <= '0;
      rd_isr_q    <= 1'b0;
      smm_q       <= 1'b0;
    end else begin
      stage_q <= stage_d;
      rd_isr_q <= rd_isr_d;
      smm_q    <= smm_d;
      if (flags_en) begin
        need_casc_q <= need_casc_d;
        need_mode_q <= need_mode_d;
      end
      if (imr_en)  imr_q  <= imr_d;
      if (base_en) base_q <= wdata[DW-1:LW];
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NLINES = 8,
  localparam int LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [NLINES-1:0] wdata,
  output logic [NLINES-1:0] rdata,
  input  logic [NLINES-1:0] irq_lines,
  input  logic              int_take,
  output logic              int_out,
  output logic [LW-1:0]     int_level,
  output logic [NLINES-1:0] int_vector
);
  logic                  rst_i_n;
  logic [NLINES-1:0]     irr_q, isr_q, isr_d, imr_q;
  logic [NLINES-1:LW]    base_q;
  logic                  rd_isr_q, smm_q, restart_hit, eoi_hit;
  seq_t                  stage_q;
  logic [NLINES-1:0]     pend, blk, pend_oh, blk_oh, svc_oh;
  logic                  pend_any, blk_any, svc_any;
  logic [LW-1:0]         pend_idx, blk_idx, svc_idx;

  irqc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  irqc_regs #(.DW(NLINES), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .imr_q(imr_q), .base_q(base_q), .rd_isr_q(rd_isr_q), .smm_q(smm_q),
    .stage_q(stage_q), .restart_hit(restart_hit), .eoi_hit(eoi_hit)
  );

  assign pend = irr_q & ~imr_q;
  assign blk  = smm_q ? (isr_q & ~imr_q) : isr_q;

  irqc_prio #(.N(NLINES)) u_pend (.vec(pend),  .any(pend_any), .idx(pend_idx), .onehot(pend_oh));
  irqc_prio #(.N(NLINES)) u_blk  (.vec(blk),   .any(blk_any),  .idx(blk_idx),  .onehot(blk_oh));
  irqc_prio #(.N(NLINES)) u_svc  (.vec(isr_q), .any(svc_any),  .idx(svc_idx),  .onehot(svc_oh));

  assign int_out    = pend_any & (~blk_any | (pend_idx < blk_idx));
  assign int_level  = pend_idx;
  assign int_vector = {base_q, pend_idx};
  assign rdata      = addr ? imr_q : (rd_isr_q ? isr_q : irr_q);

  // In-service next state
  always_comb begin
    isr_d = isr_q;
    if (restart_hit) begin
      isr_d = '0;
    end else begin
      if (eoi_hit && svc_any) isr_d = isr_d & ~svc_oh;
      if (int_take && int_out) isr_d = isr_d | pend_oh;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      irr_q <= '0;
      isr_q <= '0;
    end else begin
      irr_q <= irq_lines;
      isr_q <= isr_d;
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          addr,
  input logic [N-1:0]  wdata,
  input logic          int_take,
  input logic          int_out,
  input logic [LW-1:0] int_level,
  input logic [N-1:0]  irr,
  input logic [N-1:0]  imr,
  input logic [N-1:0]  isr,
  input logic [1:0]    stage
);
  a_r1_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (isr == '0 && imr == '0));

  a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && stage == 2'd0) |=> (imr == $past(wdata)));

  a_r3_stage_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(stage));

  a_r7_eoi_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && !wdata[7] && wdata[5] && !wdata[4] && !wdata[3] && !int_take)
    |=> ($countones(isr) == $countones($past(isr)) - (($past(isr) != '0) ? 1 : 0)));

  a_r9_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~imr) != '0));

  a_r10_take_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (int_take && int_out && !(wr_en && !addr && wdata[4])) |=> isr[$past(int_level)]);
endmodule

bind irqc_top irqc_chk #(.N(NLINES), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .int_take(int_take), .int_out(int_out), .int_level(int_level),
  .irr(irr_q), .imr(imr_q), .isr(isr_q), .stage(stage_q)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] irq_lines = 8'h00;
  logic       int_take = 1'b0;
  logic [7:0] rdata, int_vector;
  logic       int_out;
  logic [2:0] int_level;

  int checks = 0, errors = 0;
  bit chk_en = 0;

  // Reference model state
  int m_irr, m_imr, m_isr, m_base, m_stage, m_sel, m_smm, m_n3, m_n4;

  always #4 clk = ~clk;

  irqc_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_lines(irq_lines), .int_take(int_take),
    .int_out(int_out), .int_level(int_level), .int_vector(int_vector)
  );

  function automatic int lowest(int v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic int exp_level();
    int p = lowest(m_irr & ~m_imr);
    return (p == 8) ? 0 : p;
  endfunction

  function automatic bit exp_int();
    int p = lowest(m_irr & ~m_imr);
    int b = lowest(m_smm ? (m_isr & ~m_imr) : m_isr);
    return (p != 8) && (p < b);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irr = 0; m_imr = 0; m_isr = 0; m_base = 0; m_stage = 0;
      m_sel = 0; m_smm = 0; m_n3 = 0; m_n4 = 0;
    end else begin
      int nisr, p;
      bit iv;
      nisr = m_isr;
      iv = exp_int();
      p = exp_level();
      if (wr_en && !addr && wdata[4]) begin
        m_stage = 1; m_n3 = !wdata[1]; m_n4 = wdata[0];
        m_imr = 0; nisr = 0; m_sel = 0; m_smm = 0;
      end else begin
        if (wr_en && !addr && wdata[3]) begin
          if (wdata[1]) m_sel = wdata[0];
          if (wdata[6]) m_smm = wdata[5];
        end else if (wr_en && !addr && ((wdata & 8'hB8) == 8'h20)) begin
          if (lowest(m_isr) != 8) nisr[lowest(m_isr)] = 0;
        end
        if (wr_en && addr) begin
          case (m_stage)
            0: m_imr = wdata;
            1: begin m_base = wdata; m_stage = m_n3 ? 2 : (m_n4 ? 3 : 0); end
            2: m_stage = m_n4 ? 3 : 0;
            default: m_stage = 0;
          endcase
        end
        if (int_take && iv) nisr[p] = 1;
      end
      m_isr = nisr & 8'hFF;
      m_irr = irq_lines;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_en) begin
      int er;
      er = addr ? m_imr : (m_sel ? m_isr : m_irr);
      check(int_out == exp_int(), "R9 int_out", int_out, exp_int());
      check(int_level == exp_level(), "R8 int_level", int_level, exp_level());
      check(int_vector == ((m_base & 8'hF8) | exp_level()), "R2 int_vector",
            int_vector, (m_base & 8'hF8) | exp_level());
      check(rdata == er[7:0], "R5/R4 rdata", rdata, er);
    end
  end

  task automatic wr(bit a, logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(bit a, int exp, string tag);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    check(rdata == exp[7:0], tag, rdata, exp);
  endtask

  task automatic lines(logic [7:0] v);
    @(posedge clk); #1;
    irq_lines = v;
    @(posedge clk); #1;
  endtask

  task automatic take();
    @(posedge clk); #1;
    int_take = 1'b1;
    @(posedge clk); #1;
    int_take = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    chk_en = 1;
    // R11 reset state
    rd(1'b0, 8'h00, "R11 request read after reset");
    rd(1'b1, 8'h00, "R11 mask read after reset");
    @(negedge clk);
    check(int_out == 1'b0, "R11 int_out after reset", int_out, 0);

    // R1 R3: single mode with mode word: base, mode, then mask
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h01);
    wr(1'b1, 8'hF0);
    rd(1'b1, 8'hF0, "R3 mask after two setup words");

    // R8 R2: lines 2 and 3 -> level 2, vector 0x42
    lines(8'h0C);
    @(negedge clk);
    check(int_vector == 8'h42, "R2 vector for line 2", int_vector, 8'h42);
    take();
    // R5 select in-service register
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h04, "R5 in-service read after take");
    wr(1'b0, 8'h08);
    rd(1'b0, 8'h04, "R5 selection kept when enable bit clear");
    // R9 line 3 blocked by line 2 in service
    lines(8'h08);
    @(negedge clk);
    check(int_out == 1'b0, "R9 lower priority blocked", int_out, 0);
    // R10 take ignored while int_out low
    take();
    rd(1'b0, 8'h04, "R10 ignored take");
    // R6 special mask mode unblocks when line 2 masked
    wr(1'b1, 8'h04);
    @(negedge clk);
    check(int_out == 1'b0, "R6 still blocked without special mask", int_out, 0);
    wr(1'b0, 8'h68);
    @(negedge clk);
    check(int_out == 1'b1, "R6 special mask unblocks", int_out, 1);
    take();
    rd(1'b0, 8'h0C, "R10 second line taken");
    wr(1'b0, 8'h48);
    // R7 ignored command byte, then EOIs
    wr(1'b0, 8'hA0);
    rd(1'b0, 8'h0C, "R7 non-matching command ignored");
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h08, "R7 EOI clears lowest bit");
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h00, "R7 EOI on empty register");
    // R8 line 0 outranks
    lines(8'h89);
    @(negedge clk);
    check(int_level == 3'd0, "R8 line 0 highest", int_level, 0);
    // R1 restart clears and resets selection; R3 cascade path without mode word
    take();
    wr(1'b0, 8'h10);
    rd(1'b0, 8'h89, "R1 read selects request register");
    wr(1'b1, 8'h80);
    wr(1'b1, 8'h04);
    wr(1'b1, 8'h55);
    rd(1'b1, 8'h55, "R3 mask after base and cascade");
    rd(1'b0, 8'h89, "R4 request read still selected");
    lines(8'h00);
    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule